// File: doc/BRIEF.md
# Three-Phase Compressed Scan Expander

This block sits behind the link front end of a two-wire debug port. While the link runs in compressed scan mode, one bidirectional data wire carries three values in turn for every virtual four-wire scan clock. Those values are the test data in (sent inverted), the test mode select, and the test data out. The block takes one synchronised sample of that wire per link clock rising edge. It counts the three phases and rebuilds the equivalent four-wire bit stream for a downstream TAP state tracker.

Each time the data-out phase completes, the block raises a virtual clock strobe for one system clock cycle. The strobe comes with the three collected bits, and those bits hold until the next strobe. A mode-entry pulse starts the phase count at the mode-select phase and asks the attached TAP controller to go to test-logic reset. A mode-exit pulse stops the expansion. Detecting the mode and driving data back onto the wire are handled elsewhere.

Top module: `scan3_expander`

## Requirements
- R1: After reset all outputs are 0 and the block is inactive, so link edges produce no strobe until a mode-entry pulse arrives.
- R2: A mode-entry pulse sets the phase to mode-select and clears the held data-in bit to 0. The first link edge after entry is therefore taken as TMS, and the second completes a frame whose TDI is 0.
- R3: In the data-in phase, TDI takes the inverse of the sample: a sampled 0 gives TDI = 1.
- R4: In the mode-select phase, TMS takes the sample unchanged.
- R5: A link edge in the data-out phase raises `vclk_stb` one cycle later. In that same cycle it presents the held TDI, the held TMS, and TDO equal to that edge's sample.
- R6: The phase order is data-in, mode-select, data-out, and data-out wraps back to data-in.
- R7: `vclk_stb` is high for exactly one cycle, and `vtdi`, `vtms` and `vtdo` do not change between strobes.
- R8: A mode-entry pulse drives `tap_rst` high for exactly the next cycle.
- R9: A mode-exit pulse makes the block inactive and sets the phase back to data-in. While inactive, link edges produce no strobe. A later entry again starts at mode-select.
- R10: When entry is pulsed, a link edge in the same cycle is ignored. When exit is pulsed, a link edge in the same cycle is also ignored. If entry and exit arrive in the same cycle, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_edge | input | 1 | One-cycle pulse per synchronised link clock rising edge |
| link_bit | input | 1 | Data wire sample taken at that edge |
| enter | input | 1 | Pulse: compressed scan mode starts |
| leave | input | 1 | Pulse: compressed scan mode ends |
| vclk_stb | output | 1 | One-cycle virtual scan clock strobe |
| vtdi | output | 1 | Rebuilt test data in |
| vtms | output | 1 | Rebuilt test mode select |
| vtdo | output | 1 | Rebuilt test data out |
| tap_rst | output | 1 | One-cycle request to force the TAP to test-logic reset |

## Verification
The block has no parameters, so the bench builds its single fixed form. That form reaches every phase transition and the data-in inversion with both sample values. It also reaches wrap-around across many back-to-back frames, entry in the middle of a partial frame, and edges arriving while inactive. The collisions covered are entry against an edge, exit against an edge, and entry against exit. Link edges arrive both back-to-back and with idle system cycles between them, so the bench shows that strobe width and output hold do not depend on the spacing of the edges.

// File: rtl/scan3_expander.sv
module scan3_expander (
  input  logic clk,
  input  logic rst_n,
  input  logic link_edge,
  input  logic link_bit,
  input  logic enter,
  input  logic leave,
  output logic vclk_stb,
  output logic vtdi,
  output logic vtms,
  output logic vtdo,
  output logic tap_rst
);
  localparam logic [1:0] PH_IN   = 2'd0;
  localparam logic [1:0] PH_MODE = 2'd1;
  localparam logic [1:0] PH_OUT  = 2'd2;

  logic       active_q;
  logic [1:0] phase_q;
  logic       din_q, mode_q;

  wire step = active_q && link_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_IN;
      din_q    <= 1'b0;
      mode_q   <= 1'b0;
      vclk_stb <= 1'b0;
      vtdi     <= 1'b0;
      vtms     <= 1'b0;
      vtdo     <= 1'b0;
      tap_rst  <= 1'b0;
    end else begin
      vclk_stb <= 1'b0;
      tap_rst  <= enter;
      if (enter) begin
        active_q <= 1'b1;
        phase_q  <= PH_MODE;
        din_q    <= 1'b0;
      end else if (leave) begin
        active_q <= 1'b0;
        phase_q  <= PH_IN;
      end else if (step) begin
        case (phase_q)
          PH_IN: begin
            din_q   <= ~link_bit;
            phase_q <= PH_MODE;
          end
          PH_MODE: begin
            mode_q  <= link_bit;
            phase_q <= PH_OUT;
          end
          default: begin
            vtdi     <= din_q;
            vtms     <= mode_q;
            vtdo     <= link_bit;
            vclk_stb <= 1'b1;
            phase_q  <= PH_IN;
          end
        endcase
      end
    end
  end
endmodule

module scan3_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_edge,
  input logic       enter,
  input logic       leave,
  input logic       active_q,
  input logic [1:0] phase_q,
  input logic       vclk_stb,
  input logic       vtdi,
  input logic       vtms,
  input logic       vtdo,
  input logic       tap_rst
);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    vclk_stb |=> !vclk_stb);

  a_r7_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vclk_stb |-> ($stable(vtdi) && $stable(vtms) && $stable(vtdo)));

  a_r8_reset_request: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (tap_rst && active_q));

  a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_rst && !enter) |=> !tap_rst);

  a_r2_entry_phase: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (phase_q == 2'd1));

  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    vclk_stb |-> ($past(link_edge) && $past(active_q) && $past(phase_q) == 2'd2
                  && !$past(enter) && !$past(leave)));

  a_r9_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && !enter) |=> (!active_q && phase_q == 2'd0));

  a_r6_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
endmodule

bind scan3_expander scan3_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_edge(link_edge), .enter(enter), .leave(leave),
  .active_q(active_q), .phase_q(phase_q), .vclk_stb(vclk_stb), .vtdi(vtdi),
  .vtms(vtms), .vtdo(vtdo), .tap_rst(tap_rst)
);

// File: tb/tb_scan3_expander.sv
module tb_scan3_expander;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_edge = 1'b0, link_bit = 1'b0, enter = 1'b0, leave = 1'b0;
  logic vclk_stb, vtdi, vtms, vtdo, tap_rst;

  always #5 clk = ~clk;

  scan3_expander dut (
    .clk(clk), .rst_n(rst_n), .link_edge(link_edge), .link_bit(link_bit),
    .enter(enter), .leave(leave), .vclk_stb(vclk_stb), .vtdi(vtdi),
    .vtms(vtms), .vtdo(vtdo), .tap_rst(tap_rst)
  );

  int total = 0, bad = 0;
  logic [2:0] expq[$];
  logic [2:0] last_bits = 3'b000;
  logic exp_stb = 1'b0, exp_rst = 1'b0, mon_on = 1'b0;
  logic m_act = 1'b0, m_din = 1'b0, m_tms = 1'b0;
  int m_ph = 0;

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic tick(input logic e, input logic b, input logic en, input logic lv);
    @(negedge clk);
    link_edge = e; link_bit = b; enter = en; leave = lv;
    exp_stb = 1'b0;
    exp_rst = en;
    if (en) begin
      m_act = 1'b1; m_ph = 1; m_din = 1'b0;
    end else if (lv) begin
      m_act = 1'b0; m_ph = 0;
    end else if (m_act && e) begin
      case (m_ph)
        0: begin m_din = ~b; m_ph = 1; end
        1: begin m_tms = b; m_ph = 2; end
        default: begin
          expq.push_back({m_din, m_tms, b});
          exp_stb = 1'b1;
          m_ph = 0;
        end
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic frame(input logic di, input logic ms, input logic dout, input int gap);
    tick(1'b1, ~di, 1'b0, 1'b0); idle(gap);
    tick(1'b1, ms, 1'b0, 1'b0);  idle(gap);
    tick(1'b1, dout, 1'b0, 1'b0); idle(gap);
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk("R8 tap_rst", {2'b00, tap_rst}, {2'b00, exp_rst});
      chk("R7/R9 strobe", {2'b00, vclk_stb}, {2'b00, exp_stb});
      if (vclk_stb) begin
        if (expq.size() == 0) chk("R9 unexpected strobe", 3'b001, 3'b000);
        else begin
          last_bits = expq.pop_front();
          chk("R3/R4/R5 bits", {vtdi, vtms, vtdo}, last_bits);
        end
      end else begin
        chk("R7 bits hold", {vtdi, vtms, vtdo}, last_bits);
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1: reset state and edges ignored while inactive
    chk("R1 reset outputs", {vtdi, vtms, vtdo}, 3'b000);
    chk("R1 reset strobe", {1'b0, vclk_stb, tap_rst}, 3'b000);
    repeat (6) tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R1 no strobe inactive", {2'b00, vclk_stb}, 3'b000);

    // R2 / R8: entry starts at mode-select, held data-in cleared
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R2 first frame", {vtdi, vtms, vtdo}, 3'b011);

    // R3, R4, R5, R6: all bit patterns, back-to-back and spaced edges
    for (int p = 0; p < 8; p++) frame(p[2], p[1], p[0], p % 3);
    idle(1);
    chk("R6 last of wrapped frames", {vtdi, vtms, vtdo}, 3'b111);
    frame(1'b1, 1'b0, 1'b0, 0);
    idle(1);
    chk("R3 sample 0 gives TDI 1", {vtdi, vtms, vtdo}, 3'b100);

    // R9: exit mid-frame, edges ignored, re-entry at mode-select
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (5) tick(1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R9 held bits after exit", {vtdi, vtms, vtdo}, 3'b100);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R9 re-entry frame", {vtdi, vtms, vtdo}, 3'b001);

    // R10: entry with an edge, exit with an edge, entry with exit
    frame(1'b0, 1'b1, 1'b0, 0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R10 edge ignored at entry", {vtdi, vtms, vtdo}, 3'b001);
    tick(1'b1, 1'b1, 1'b0, 1'b1);
    tick(1'b1, 1'b0, 1'b1, 1'b1);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R10 entry wins over exit", {vtdi, vtms, vtdo}, 3'b010);

    // long run of wrapped frames
    for (int k = 0; k < 40; k++) frame(k[0], k[1], k[2], k % 2);
    idle(3);
    chk("R5 queue drained", {1'b0, expq.size() == 0, 1'b0}, 3'b010);

    mon_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule